// File: doc/BRIEF.md
# Clock Tree Frequency Resolver

This block works out, on request, the frequency in hertz of one of a handful of clock roots, given the mux codes and divider fields that steer the clock tree. The caller presents a clock identifier together with the present tree settings and pulses `start`. The block copies the settings, walks the tree stage by stage, and returns a 32-bit frequency together with a one-cycle `done` pulse. Constant roots answer at once. Roots that depend on the tree pass through a chain of integer divisions.

The tree starts from a 24 MHz crystal. A system PLL multiplies it by 20 or 22, and a second PLL multiplies it by a fixed 20. Two fractional taps each give the system PLL frequency times 18 divided by a 6-bit fraction. A main-source mux and an alternate-source path feed the peripheral root. Below that root sit the bus divider and the peripheral-bus divider, and a timer root with its own source choice and divider.

All products are constants folded at elaboration. The only arithmetic is one shared iterative restoring divider, which gives a fixed latency of 66 cycles per division stage.

Top module: `clk_freq_resolver`

## Requirements
- R1: While reset is held and after it is released, with no request made, `busy`, `done` and `freq` are all 0. Reset is asserted asynchronously and released through a synchronizer.
- R2: Constant identifiers answer with `done` one cycle after the accepting edge, and `busy` never rises. Identifier 3 gives 32768, identifier 4 gives 24000000 and identifier 5 gives 3000000.
- R3: Identifier 0 and the unused identifiers 6 and 7 return 0 with the same one-cycle timing as R2.
- R4: With `root_alt`=0 and `main_src`=0, the peripheral root is the system PLL: 528000000 when `sys_x22`=1 and 480000000 when it is 0.
- R5: `main_src` codes 1, 2 and 3 take tap 2, tap 0, and tap 2 halved. A tap is floor(PLL×18 / fraction), and each stage truncates.
- R6: With `root_alt`=1, `alt_src` code 0 gives 480000000, code 1 gives 24000000, and codes 2 and 3 give 0. The result is then divided by `alt_div`+1.
- R7: Identifier 1 (peripheral bus) returns floor(floor(root/(`ahb_div`+1))/(`pbus_div`+1)).
- R8: A tap whose fraction field is 0 yields 0 Hz, and no division by zero takes place.
- R9: Identifier 2 (timer root) takes the peripheral-bus value when `per_xtal`=0, or 24000000 when it is 1, and divides it by `per_div`+1.
- R10: A tree request keeps `busy` high from the accepting edge. `done` comes 66·n edges later, where n is 3 for identifier 1, one more when `main_src`=3 on the main path, and one more for identifier 2.
- R11: While busy, `start` is ignored and input changes have no effect, because the settings and identifier are captured on the accepting edge.
- R12: `done` lasts one cycle and `freq` holds its last result until the next one. A new request is accepted in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| clk_id | input | 3 | Root selector (see R2, R3, R7, R9) |
| sys_x22 | input | 1 | System PLL multiplier: 1 selects ×22, 0 selects ×20 |
| tap0_frac | input | 6 | Fraction of tap 0 |
| tap2_frac | input | 6 | Fraction of tap 2 |
| alt_src | input | 2 | Alternate-path source code |
| main_src | input | 2 | Main-path source code |
| root_alt | input | 1 | 1 selects the alternate path for the peripheral root |
| alt_div | input | 3 | Alternate-path divider minus one |
| ahb_div | input | 3 | Bus divider minus one |
| pbus_div | input | 2 | Peripheral-bus divider minus one |
| per_xtal | input | 1 | Timer root source: 1 selects the crystal |
| per_div | input | 6 | Timer root divider minus one |
| busy | output | 1 | A tree walk is in progress |
| done | output | 1 | One-cycle result strobe |
| freq | output | 32 | Last computed frequency in Hz |

## Verification
Each source code on both the main and alternate paths is run with fixed fields that make the expected value easy to read. Odd tap fractions and non-trivial dividers show where truncation happens between stages, and a zero fraction checks that a tap never divides by zero. A timer-root run with each source setting separates the crystal from the peripheral-bus value. A request carrying one set of fields is then disturbed by new fields and a second start while it is running, which shows that the settings were captured and the second start was dropped. A run of random settings is compared against a behavioural model on every cycle, checking latency as well as value.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  localparam longint unsigned XTAL_HZ   = 64'd24_000_000;
  localparam longint unsigned SLOW_HZ   = 64'd32_768;
  localparam longint unsigned SYS_LO_HZ = XTAL_HZ * 20;
  localparam longint unsigned SYS_HI_HZ = XTAL_HZ * 22;
  localparam longint unsigned USB_HZ    = XTAL_HZ * 20;
  localparam longint unsigned TAP_MUL   = 64'd18;
  localparam longint unsigned TAP_LO_HZ = SYS_LO_HZ * TAP_MUL;
  localparam longint unsigned TAP_HI_HZ = SYS_HI_HZ * TAP_MUL;

  localparam int unsigned ID_W     = 3;
  localparam int unsigned FRAC_W   = 6;
  localparam int unsigned ALTDIV_W = 3;
  localparam int unsigned AHBDIV_W = 3;
  localparam int unsigned PBDIV_W  = 2;
  localparam int unsigned PERDIV_W = 6;

  localparam logic [ID_W-1:0] ID_NONE    = 3'd0;
  localparam logic [ID_W-1:0] ID_PBUS    = 3'd1;
  localparam logic [ID_W-1:0] ID_PER     = 3'd2;
  localparam logic [ID_W-1:0] ID_SLOW    = 3'd3;
  localparam logic [ID_W-1:0] ID_XTAL    = 3'd4;
  localparam logic [ID_W-1:0] ID_XTAL_D8 = 3'd5;

  localparam logic [1:0] ALT_USB  = 2'd0;
  localparam logic [1:0] ALT_XTAL = 2'd1;

  localparam logic [1:0] MAIN_SYS       = 2'd0;
  localparam logic [1:0] MAIN_TAP2      = 2'd1;
  localparam logic [1:0] MAIN_TAP0      = 2'd2;
  localparam logic [1:0] MAIN_TAP2_HALF = 2'd3;

  typedef struct packed {
    logic                sys_x22;
    logic [FRAC_W-1:0]   tap0_frac;
    logic [FRAC_W-1:0]   tap2_frac;
    logic [1:0]          alt_src;
    logic [1:0]          main_src;
    logic                root_alt;
    logic [ALTDIV_W-1:0] alt_div;
    logic [AHBDIV_W-1:0] ahb_div;
    logic [PBDIV_W-1:0]  pbus_div;
    logic                per_xtal;
    logic [PERDIV_W-1:0] per_div;
  } tree_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ROOT   = 3'd1,
    S_HALF   = 3'd2,
    S_AHB    = 3'd3,
    S_PBUS   = 3'd4,
    S_PER    = 3'd5,
    S_WAIT   = 3'd6
  } walk_state_e;

endpackage

// File: rtl/cfr_rst_sync.sv
module cfr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfr_div.sv
module cfr_div #(
  parameter int unsigned DVD_W = 64,
  parameter int unsigned DVS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dvd,
  input  logic [DVS_W-1:0] dvs,
  output logic             done,
  output logic [DVD_W-1:0] quo
);

  localparam int unsigned      CNT_W    = $clog2(DVD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DVD_W - 1);

  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DVD_W-1:0] shf_q, shf_d;
  logic [DVS_W-1:0] rem_q, rem_d;
  logic [DVS_W-1:0] dvs_q, dvs_d;

  logic [DVS_W:0]   rem_sh;
  logic [DVS_W:0]   rem_sub;
  logic             fits;

  // one restoring step: bring in the next dividend bit, try a subtract
  always_comb begin
    rem_sh  = {rem_q, shf_q[DVD_W-1]};
    rem_sub = rem_sh - {1'b0, dvs_q};
    fits    = ~rem_sub[DVS_W];
  end

  always_comb begin
    run_d  = run_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    shf_d  = shf_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    if (go && !run_q) begin
      run_d = 1'b1;
      cnt_d = '0;
      shf_d = dvd;
      rem_d = '0;
      dvs_d = dvs;
    end else if (run_q) begin
      shf_d = {shf_q[DVD_W-2:0], fits};
      rem_d = fits ? rem_sub[DVS_W-1:0] : rem_sh[DVS_W-1:0];
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      shf_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      shf_q  <= shf_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
    end
  end

  assign done = done_q;
  assign quo  = shf_q;

  // R8: the walker never hands over a zero divisor
  p_divisor_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> dvs != '0);

  // R10: a new division is only launched while the divider is idle
  p_go_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run_q);

  // R12: the completion strobe is a single cycle
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/cfr_seq.sv
module cfr_seq
  import cfr_pkg::*;
#(
  parameter int unsigned ACC_W  = 64,
  parameter int unsigned DVS_W  = 8,
  parameter int unsigned FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ID_W-1:0]   clk_id,
  input  tree_cfg_t         cfg_in,
  output logic              div_go,
  output logic [ACC_W-1:0]  div_dvd,
  output logic [DVS_W-1:0]  div_dvs,
  input  logic              div_done,
  input  logic [ACC_W-1:0]  div_quo,
  output logic              busy,
  output logic              done,
  output logic [FREQ_W-1:0] freq
);

  walk_state_e       state_q, state_d;
  walk_state_e       ret_q, ret_d;
  tree_cfg_t         cfg_q;
  logic [ID_W-1:0]   id_q;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [FREQ_W-1:0] freq_q, freq_d;
  logic              done_q, done_d;
  logic              cap_en, acc_en, freq_en;

  logic [ACC_W-1:0]  sys_hz;
  logic [ACC_W-1:0]  tap_base;
  logic [FRAC_W-1:0] tap_frac;

  always_comb begin
    sys_hz   = cfg_q.sys_x22 ? ACC_W'(SYS_HI_HZ) : ACC_W'(SYS_LO_HZ);
    tap_base = cfg_q.sys_x22 ? ACC_W'(TAP_HI_HZ) : ACC_W'(TAP_LO_HZ);
    tap_frac = (cfg_q.main_src == MAIN_TAP0) ? cfg_q.tap0_frac : cfg_q.tap2_frac;
  end

  assign cap_en = (state_q == S_IDLE) && start;

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    acc_d   = acc_q;
    freq_d  = freq_q;
    done_d  = 1'b0;
    acc_en  = 1'b0;
    freq_en = 1'b0;
    div_go  = 1'b0;
    div_dvd = acc_q;
    div_dvs = DVS_W'(1);
    case (state_q)
      S_IDLE: begin
        if (start) begin
          case (clk_id)
            ID_PBUS, ID_PER: state_d = S_ROOT;
            ID_SLOW: begin
              freq_d = FREQ_W'(SLOW_HZ); freq_en = 1'b1; done_d = 1'b1;
            end
            ID_XTAL: begin
              freq_d = FREQ_W'(XTAL_HZ); freq_en = 1'b1; done_d = 1'b1;
            end
            ID_XTAL_D8: begin
              freq_d = FREQ_W'(XTAL_HZ / 8); freq_en = 1'b1; done_d = 1'b1;
            end
            default: begin
              freq_d = '0; freq_en = 1'b1; done_d = 1'b1;
            end
          endcase
        end
      end
      S_ROOT: begin
        div_go  = 1'b1;
        state_d = S_WAIT;
        ret_d   = S_AHB;
        if (cfg_q.root_alt) begin
          div_dvs = DVS_W'(cfg_q.alt_div) + DVS_W'(1);
          case (cfg_q.alt_src)
            ALT_USB:  div_dvd = ACC_W'(USB_HZ);
            ALT_XTAL: div_dvd = ACC_W'(XTAL_HZ);
            default:  div_dvd = '0;
          endcase
        end else if (cfg_q.main_src == MAIN_SYS) begin
          div_dvd = sys_hz;
        end else begin
          if (tap_frac == '0) begin
            div_dvd = '0;
          end else begin
            div_dvd = tap_base;
            div_dvs = DVS_W'(tap_frac);
          end
          if (cfg_q.main_src == MAIN_TAP2_HALF) ret_d = S_HALF;
        end
      end
      S_HALF: begin
        div_go  = 1'b1;
        div_dvs = DVS_W'(2);
        state_d = S_WAIT;
        ret_d   = S_AHB;
      end
      S_AHB: begin
        div_go  = 1'b1;
        div_dvs = DVS_W'(cfg_q.ahb_div) + DVS_W'(1);
        state_d = S_WAIT;
        ret_d   = S_PBUS;
      end
      S_PBUS: begin
        div_go  = 1'b1;
        div_dvs = DVS_W'(cfg_q.pbus_div) + DVS_W'(1);
        state_d = S_WAIT;
        ret_d   = (id_q == ID_PER) ? S_PER : S_IDLE;
      end
      S_PER: begin
        div_go  = 1'b1;
        div_dvd = cfg_q.per_xtal ? ACC_W'(XTAL_HZ) : acc_q;
        div_dvs = DVS_W'(cfg_q.per_div) + DVS_W'(1);
        state_d = S_WAIT;
        ret_d   = S_IDLE;
      end
      S_WAIT: begin
        if (div_done) begin
          state_d = ret_q;
          if (ret_q == S_IDLE) begin
            freq_d  = div_quo[FREQ_W-1:0];
            freq_en = 1'b1;
            done_d  = 1'b1;
          end else begin
            acc_d  = div_quo;
            acc_en = 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ret_q   <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      id_q  <= '0;
    end else if (cap_en) begin
      cfg_q <= cfg_in;
      id_q  <= clk_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
    end else if (freq_en) begin
      freq_q <= freq_d;
    end
  end

  assign busy = (state_q != S_IDLE);
  assign done = done_q;
  assign freq = freq_q;

  // R11: a start seen mid-walk leaves the captured request untouched
  p_busy_ignores_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) && start |=> $stable(cfg_q) && $stable(id_q));

  // R12: a result is only announced once the walker is back at rest
  p_done_at_rest_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> state_q == S_IDLE);

  // R10: the divider only reports while the walker is waiting on it
  p_div_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> state_q == S_WAIT);

  // R2: the crystal identifier always answers with the crystal constant
  p_xtal_constant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && (id_q == ID_XTAL) |-> freq_q == FREQ_W'(XTAL_HZ));

endmodule

// File: rtl/clk_freq_resolver.sv
module clk_freq_resolver
  import cfr_pkg::*;
#(
  parameter int unsigned ACC_W       = 64,
  parameter int unsigned DVS_W       = 8,
  parameter int unsigned FREQ_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        clk_id,
  input  logic              sys_x22,
  input  logic [5:0]        tap0_frac,
  input  logic [5:0]        tap2_frac,
  input  logic [1:0]        alt_src,
  input  logic [1:0]        main_src,
  input  logic              root_alt,
  input  logic [2:0]        alt_div,
  input  logic [2:0]        ahb_div,
  input  logic [1:0]        pbus_div,
  input  logic              per_xtal,
  input  logic [5:0]        per_div,
  output logic              busy,
  output logic              done,
  output logic [FREQ_W-1:0] freq
);

  logic             core_rst_n;
  tree_cfg_t        cfg;
  logic             div_go;
  logic [ACC_W-1:0] div_dvd;
  logic [DVS_W-1:0] div_dvs;
  logic             div_done;
  logic [ACC_W-1:0] div_quo;

  always_comb begin
    cfg.sys_x22   = sys_x22;
    cfg.tap0_frac = tap0_frac;
    cfg.tap2_frac = tap2_frac;
    cfg.alt_src   = alt_src;
    cfg.main_src  = main_src;
    cfg.root_alt  = root_alt;
    cfg.alt_div   = alt_div;
    cfg.ahb_div   = ahb_div;
    cfg.pbus_div  = pbus_div;
    cfg.per_xtal  = per_xtal;
    cfg.per_div   = per_div;
  end

  cfr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (core_rst_n)
  );

  cfr_seq #(.ACC_W(ACC_W), .DVS_W(DVS_W), .FREQ_W(FREQ_W)) u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .start    (start),
    .clk_id   (clk_id),
    .cfg_in   (cfg),
    .div_go   (div_go),
    .div_dvd  (div_dvd),
    .div_dvs  (div_dvs),
    .div_done (div_done),
    .div_quo  (div_quo),
    .busy     (busy),
    .done     (done),
    .freq     (freq)
  );

  cfr_div #(.DVD_W(ACC_W), .DVS_W(DVS_W)) u_div (
    .clk   (clk),
    .rst_n (core_rst_n),
    .go    (div_go),
    .dvd   (div_dvd),
    .dvs   (div_dvs),
    .done  (div_done),
    .quo   (div_quo)
  );

endmodule

// File: tb/tb_clk_freq_resolver.sv
`timescale 1ns/1ps
module tb_clk_freq_resolver;

  localparam int ACC_W = 64;
  localparam int STEP  = ACC_W + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  clk_id = '0;
  logic        b_x22 = 1'b1;
  logic [5:0]  b_tap0 = 6'd27, b_tap2 = 6'd24;
  logic [1:0]  b_alt_src = '0, b_main = '0;
  logic        b_root_alt = 1'b0;
  logic [2:0]  b_alt_div = '0, b_ahb = '0;
  logic [1:0]  b_pbus = '0;
  logic        b_per_xtal = 1'b0;
  logic [5:0]  b_per_div = '0;
  logic        busy, done;
  logic [31:0] freq;

  clk_freq_resolver #(.ACC_W(ACC_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_id(clk_id),
    .sys_x22(b_x22), .tap0_frac(b_tap0), .tap2_frac(b_tap2),
    .alt_src(b_alt_src), .main_src(b_main), .root_alt(b_root_alt),
    .alt_div(b_alt_div), .ahb_div(b_ahb), .pbus_div(b_pbus),
    .per_xtal(b_per_xtal), .per_div(b_per_div),
    .busy(busy), .done(done), .freq(freq)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    cmp_en = 1'b0;
  string cur_req = "R1";

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void ref_eval(input logic [2:0] id, output longint unsigned f, output int n);
    longint unsigned sys, tap, root, ahb, pb;
    int frac;
    f = 0; n = 0; root = 0;
    sys = b_x22 ? 64'd528000000 : 64'd480000000;
    case (id)
      3'd3: f = 32768;
      3'd4: f = 24000000;
      3'd5: f = 3000000;
      3'd1, 3'd2: begin
        n = 3;
        if (b_root_alt) begin
          case (b_alt_src)
            2'd0:    root = 480000000;
            2'd1:    root = 24000000;
            default: root = 0;
          endcase
          root = root / (longint'(b_alt_div) + 1);
        end else if (b_main == 2'd0) begin
          root = sys;
        end else begin
          frac = (b_main == 2'd2) ? int'(b_tap0) : int'(b_tap2);
          tap  = (frac == 0) ? 0 : (sys * 18) / longint'(frac);
          if (b_main == 2'd3) begin root = tap / 2; n = 4; end
          else root = tap;
        end
        ahb = root / (longint'(b_ahb) + 1);
        pb  = ahb / (longint'(b_pbus) + 1);
        if (id == 3'd2) begin
          n++;
          f = (b_per_xtal ? 64'd24000000 : pb) / (longint'(b_per_div) + 1);
        end else begin
          f = pb;
        end
      end
      default: f = 0;
    endcase
  endfunction

  // behavioural reference: latency counter and result
  bit              m_busy = 0, m_done = 0;
  longint unsigned m_freq = 0, m_pend = 0;
  int              m_cnt = 0;

  always @(posedge clk) begin
    longint unsigned f;
    int n;
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_freq = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; m_freq = m_pend; end
      end else if (start) begin
        ref_eval(clk_id, f, n);
        if (n == 0) begin m_done = 1; m_freq = f; end
        else begin m_busy = 1; m_cnt = n * STEP; m_pend = f; end
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check("R10", 64'(busy), 64'(m_busy));
      check("R12", 64'(done), 64'(m_done));
      check(cur_req, 64'(freq), m_freq[31:0]);
    end
  end

  task automatic run(input string req, input logic [2:0] id);
    longint unsigned f;
    int n, guard;
    cur_req = req;
    ref_eval(id, f, n);
    clk_id = id;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    guard  = 0;
    while (!done && guard < 1000) begin @(negedge clk); guard++; end
    check(req, 64'(freq), f[31:0]);
    @(negedge clk);
  endtask

  task automatic defaults();
    b_x22 = 1'b1; b_tap0 = 6'd27; b_tap2 = 6'd24; b_alt_src = 2'd0; b_main = 2'd0;
    b_root_alt = 1'b0; b_alt_div = 3'd0; b_ahb = 3'd0; b_pbus = 2'd0;
    b_per_xtal = 1'b0; b_per_div = 6'd0;
  endtask

  initial begin
    longint unsigned exp_f;
    int exp_n, guard;
    cmp_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs at rest while reset held
    check("R1", 64'(busy), 0); check("R1", 64'(done), 0); check("R1", 64'(freq), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", 64'(busy), 0); check("R1", 64'(freq), 0);

    // R2 / R3: constant and unused identifiers
    run("R2", 3'd4); run("R2", 3'd5); run("R2", 3'd3);
    run("R3", 3'd0); run("R3", 3'd6); run("R3", 3'd7);

    // R4: system PLL straight through
    defaults(); run("R4", 3'd1);
    b_x22 = 1'b0; run("R4", 3'd1);

    // R5: fractional taps, including an odd fraction and the halved tap
    defaults(); b_main = 2'd1; run("R5", 3'd1);
    b_main = 2'd2; run("R5", 3'd1);
    b_main = 2'd3; run("R5", 3'd1);
    b_main = 2'd2; b_tap0 = 6'd35; b_x22 = 1'b0; run("R5", 3'd1);

    // R6: alternate path sources and divider
    defaults(); b_root_alt = 1'b1;
    b_alt_src = 2'd0; run("R6", 3'd1);
    b_alt_src = 2'd1; b_alt_div = 3'd2; run("R6", 3'd1);
    b_alt_src = 2'd2; run("R6", 3'd1);
    b_alt_src = 2'd3; run("R6", 3'd1);

    // R7: bus and peripheral-bus dividers
    defaults(); b_ahb = 3'd3; b_pbus = 2'd1; run("R7", 3'd1);
    b_ahb = 3'd6; b_pbus = 2'd2; b_main = 2'd3; b_tap2 = 6'd29; run("R7", 3'd1);

    // R8: zero fraction
    defaults(); b_main = 2'd1; b_tap2 = 6'd0; run("R8", 3'd1);
    b_main = 2'd2; b_tap0 = 6'd0; run("R8", 3'd2);

    // R9: timer root from each source
    defaults(); b_ahb = 3'd3; b_pbus = 2'd1; b_per_div = 6'd5; run("R9", 3'd2);
    b_per_xtal = 1'b1; b_per_div = 6'd0; run("R9", 3'd2);
    b_per_div = 6'd63; run("R9", 3'd2);

    // R11: start and field changes while busy are ignored
    defaults(); b_main = 2'd1; b_tap2 = 6'd30; b_ahb = 3'd1;
    cur_req = "R11";
    ref_eval(3'd1, exp_f, exp_n);
    clk_id = 3'd1; start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    b_main = 2'd0; b_x22 = 1'b0; b_ahb = 3'd4; clk_id = 3'd4;
    start = 1'b1; @(negedge clk); start = 1'b0;
    guard = 0;
    while (!done && guard < 1000) begin @(negedge clk); guard++; end
    check("R11", 64'(freq), exp_f[31:0]);
    // R12: done falls after one cycle, result held
    @(negedge clk);
    check("R12", 64'(done), 0);
    check("R12", 64'(freq), exp_f[31:0]);

    // R12: back-to-back request accepted in the done cycle
    defaults(); clk_id = 3'd5; start = 1'b1; @(negedge clk);
    check("R12", 64'(done), 1);
    clk_id = 3'd3; @(negedge clk); start = 1'b0;
    check("R12", 64'(freq), 32768);
    @(negedge clk);

    // R7: random settings, compared cycle by cycle
    for (int i = 0; i < 40; i++) begin
      b_x22 = 1'($urandom); b_tap0 = 6'($urandom); b_tap2 = 6'($urandom);
      b_alt_src = 2'($urandom); b_main = 2'($urandom); b_root_alt = 1'($urandom);
      b_alt_div = 3'($urandom); b_ahb = 3'($urandom); b_pbus = 2'($urandom);
      b_per_xtal = 1'($urandom); b_per_div = 6'($urandom);
      run("R7", 3'($urandom_range(1, 2)));
    end

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule